// File: doc/BRIEF.md
# Linked-List Descriptor Transfer Engine

This block is a single-channel transfer engine driven by a chain of four-word descriptors held in memory. Software places a descriptor address in the next-pointer register and raises the run input. The engine reads the descriptor through a word-wide memory master port. It then moves the requested number of bytes, one word per beat, between memory and the selected peripheral, and writes the closing status back into the descriptor.

Processing of a descriptor ends for one of three reasons: the byte count runs out (finished), the peripheral signals completion (done), or the transfer is abandoned (terminated). Terminated means run was dropped or the bus watchdog expired. Each of the first two reasons has its own interrupt-enable and chain-enable bit in the descriptor. The closing bits accumulate in the written-back word, and a zero link ends the list.

Top module: `ddx_engine`

## Requirements
- R1: When idle with run high, after a write to the next-pointer register with a nonzero value P, the engine reads four words at byte addresses P, P+4, P+8 and P+12. These are taken, in that order, as control word, current address, device word and link. The link becomes the new next-pointer value.
- R2: The control word is laid out as follows: byte count [17:0], device select [20:18], device command [24:21], chain-on-finished bit 25, chain-on-done bit 26, irq-on-finished bit 27, irq-on-done bit 28, terminated bit 29, done bit 30, finished bit 31. After the fetch, dev_start pulses for one cycle. During that pulse dev_sel, dev_cmd and dev_csin carry the select field, the command field and the device word.
- R3: Command bit 0 set moves memory to device, and clear moves device to memory. Each beat moves one word at the current address. It then lowers the count by min(4, count) and raises the address by the same amount.
- R4: When the count reaches zero, processing ends with the finished bit set. A descriptor loaded with count zero finishes without any data beat.
- R5: A dev_done pulse ends processing after the beat in progress, with the done bit set. The count and address keep the values left by the last completed beat. Done outranks finished when both apply at the same decision.
- R6: Run low at a beat boundary, or bus_timeout high during a beat, ends processing with the terminated bit set. A timed-out beat is not counted. A terminated descriptor never chains, and termination outranks the other causes.
- R7: The write-back stores three words at P, P+4 and P+8. These are the control word with the updated count, the advanced address, and dev_status sampled at completion. Closing bits that were already set in the loaded control word stay set.
- R8: The status flags are set as follows: D on a done end with irq-on-done set, and F on a finished end with irq-on-finished set. A stat_wr cycle clears F when stat_wdata bit 0 is set and clears D when bit 1 is set. irq is the OR of D and F.
- R9: After write-back, the engine fetches the descriptor at the link in two cases: a finished end with chain-on-finished set, or a done end with chain-on-done set. It does so only when the link is nonzero; otherwise it returns to idle.
- R10: After reset, busy, irq and both master request outputs are low. busy is high from the start of a fetch until the engine returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| run | input | 1 | Channel enable; dropping it during a transfer terminates it |
| ndptr_wr | input | 1 | Loads the next-pointer register and arms a start (accepted when idle) |
| ndptr_wdata | input | AW | Next-pointer value |
| stat_wr | input | 1 | Write-one-to-clear strobe for the status flags |
| stat_wdata | input | 2 | Bit 0 clears F, bit 1 clears D |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge; the transfer completes on req and ack |
| mem_rdata | input | 32 | Memory read data, valid with ack |
| dev_start | output | 1 | One-cycle pulse when a descriptor operation begins |
| dev_sel | output | 3 | Selected peripheral |
| dev_cmd | output | 4 | Peripheral command |
| dev_csin | output | 32 | Device word from the descriptor |
| dev_req | output | 1 | Peripheral data request |
| dev_we | output | 1 | 1: engine writes data to the peripheral |
| dev_wdata | output | 32 | Data to the peripheral |
| dev_ack | input | 1 | Peripheral acknowledge |
| dev_rdata | input | 32 | Data from the peripheral, valid with ack |
| dev_done | input | 1 | Peripheral completion pulse |
| dev_status | input | 32 | Peripheral status, written back at completion |
| bus_timeout | input | 1 | Bus transaction timer expiry |
| busy | output | 1 | Engine is working on a descriptor list |
| stat_d | output | 1 | Done interrupt flag |
| stat_f | output | 1 | Finished interrupt flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the engine with AW=12, so every descriptor and data buffer fits in a 1024-word memory model whose words are indexed directly by address. The peripheral model can stall its acknowledge, raise done on a chosen beat, and drop run after a chosen beat. This makes each of the three end causes reachable on an exact, predictable beat. The cases covered include a descriptor with a partial last word, a two-descriptor chain in the device-to-memory direction, a zero count, and pre-set closing bits.

// File: rtl/ddx_pkg.sv
package ddx_pkg;
  localparam int WORD_W     = 32;
  localparam int WORD_B     = WORD_W / 8;
  localparam int BYTE_SH    = $clog2(WORD_B);
  localparam int DESC_WORDS = 4;
  localparam int IDX_W      = $clog2(DESC_WORDS);
  localparam int CNT_W      = 18;
  localparam int SEL_W      = 3;
  localparam int CMD_W      = 4;
  localparam int SEL_LSB    = CNT_W;
  localparam int CMD_LSB    = SEL_LSB + SEL_W;
  localparam int COF_BIT    = CMD_LSB + CMD_W;
  localparam int COD_BIT    = COF_BIT + 1;
  localparam int IOF_BIT    = COD_BIT + 1;
  localparam int IOD_BIT    = IOF_BIT + 1;
  localparam int TRM_BIT    = IOD_BIT + 1;
  localparam int DON_BIT    = TRM_BIT + 1;
  localparam int FIN_BIT    = DON_BIT + 1;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_START, S_DECIDE, S_BEAT_A, S_BEAT_B, S_WB
  } state_t;

  typedef enum logic [1:0] {C_NONE, C_FIN, C_DONE, C_TERM} cause_t;

  // bytes carried by one beat: a full word or what is left
  function automatic logic [CNT_W-1:0] step_bytes(input logic [CNT_W-1:0] cnt);
    return (cnt > CNT_W'(WORD_B)) ? CNT_W'(WORD_B) : cnt;
  endfunction

  // sticky merge of the closing cause into the control word
  function automatic logic [WORD_W-1:0] close_ctl(input logic [WORD_W-1:0] ctl,
                                                  input cause_t c);
    logic [WORD_W-1:0] r;
    r = ctl;
    if (c == C_FIN)  r[FIN_BIT] = 1'b1;
    if (c == C_DONE) r[DON_BIT] = 1'b1;
    if (c == C_TERM) r[TRM_BIT] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/ddx_beat.sv
module ddx_beat
  import ddx_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [AW-1:0]    addr,
  output logic [CNT_W-1:0] nxt_cnt,
  output logic [AW-1:0]    nxt_addr
);
  logic [CNT_W-1:0] step;

  assign step     = step_bytes(cnt);
  assign nxt_cnt  = cnt - step;
  assign nxt_addr = addr + AW'(step);
endmodule

// File: rtl/ddx_status.sv
module ddx_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_d,
  input  logic       set_f,
  input  logic       clr_wr,
  input  logic [1:0] clr_bits,
  output logic       flag_d,
  output logic       flag_f,
  output logic       irq
);
  logic clr_f, clr_d;

  assign clr_f = clr_wr & clr_bits[0];
  assign clr_d = clr_wr & clr_bits[1];

  // a new event wins over a simultaneous clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_d <= 1'b0;
      flag_f <= 1'b0;
    end else begin
      flag_d <= set_d | (flag_d & ~clr_d);
      flag_f <= set_f | (flag_f & ~clr_f);
    end
  end

  assign irq = flag_d | flag_f;

  p_w1c_f_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_f && !set_f) |=> !flag_f);
  p_w1c_d_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_d && !set_d) |=> !flag_d);
  p_set_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_d || set_f) |=> irq);
endmodule

// File: rtl/ddx_engine.sv
module ddx_engine
  import ddx_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              ndptr_wr,
  input  logic [AW-1:0]     ndptr_wdata,
  input  logic              stat_wr,
  input  logic [1:0]        stat_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              dev_start,
  output logic [SEL_W-1:0]  dev_sel,
  output logic [CMD_W-1:0]  dev_cmd,
  output logic [WORD_W-1:0] dev_csin,
  output logic              dev_req,
  output logic              dev_we,
  output logic [WORD_W-1:0] dev_wdata,
  input  logic              dev_ack,
  input  logic [WORD_W-1:0] dev_rdata,
  input  logic              dev_done,
  input  logic [WORD_W-1:0] dev_status,
  input  logic              bus_timeout,
  output logic              busy,
  output logic              stat_d,
  output logic              stat_f,
  output logic              irq
);
  localparam logic [IDX_W-1:0] LAST_FETCH = IDX_W'(DESC_WORDS - 1);
  localparam logic [IDX_W-1:0] LAST_WB    = IDX_W'(DESC_WORDS - 2);

  state_t               state;
  cause_t               cause, dec_cause;
  logic [IDX_W-1:0]     widx;
  logic [AW-1:0]        dptr, ndptr, cur_addr, nxt_addr;
  logic [WORD_W-1:0]    ctl, devcs, data_q;
  logic [CNT_W-1:0]     nxt_cnt;
  logic                 arm, done_seen;

  // named events
  logic dir_m2d, mem_fire, dev_fire, fire_a, fire_b;
  logic beat_done, wb_last, chain_go, start_go, set_d, set_f;

  assign dir_m2d   = ctl[CMD_LSB];
  assign mem_fire  = mem_req & mem_ack;
  assign dev_fire  = dev_req & dev_ack;
  assign fire_a    = dir_m2d ? mem_fire : dev_fire;
  assign fire_b    = dir_m2d ? dev_fire : mem_fire;
  assign beat_done = (state == S_BEAT_B) && fire_b && !bus_timeout;
  assign wb_last   = (state == S_WB) && mem_fire && (widx == LAST_WB);
  assign chain_go  = ((cause == C_FIN)  && ctl[COF_BIT]) ||
                     ((cause == C_DONE) && ctl[COD_BIT]);
  assign start_go  = run && arm && (ndptr != '0);
  assign set_d     = wb_last && (cause == C_DONE) && ctl[IOD_BIT];
  assign set_f     = wb_last && (cause == C_FIN)  && ctl[IOF_BIT];

  // priority: abort, then device done, then exhausted count
  always_comb begin
    if (!run || bus_timeout)        dec_cause = C_TERM;
    else if (done_seen || dev_done) dec_cause = C_DONE;
    else if (ctl[CNT_W-1:0] == '0)  dec_cause = C_FIN;
    else                            dec_cause = C_NONE;
  end

  ddx_beat #(.AW(AW)) u_beat (
    .cnt(ctl[CNT_W-1:0]), .addr(cur_addr), .nxt_cnt(nxt_cnt), .nxt_addr(nxt_addr)
  );

  ddx_status u_status (
    .clk(clk), .rst_n(rst_n), .set_d(set_d), .set_f(set_f),
    .clr_wr(stat_wr), .clr_bits(stat_wdata),
    .flag_d(stat_d), .flag_f(stat_f), .irq(irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cause     <= C_NONE;
      widx      <= '0;
      dptr      <= '0;
      ndptr     <= '0;
      cur_addr  <= '0;
      ctl       <= '0;
      devcs     <= '0;
      data_q    <= '0;
      arm       <= 1'b0;
      done_seen <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (ndptr_wr) begin
            ndptr <= ndptr_wdata;
            arm   <= 1'b1;
          end else if (start_go) begin
            state <= S_FETCH;
            dptr  <= ndptr;
            widx  <= '0;
            arm   <= 1'b0;
          end
        end
        S_FETCH: begin
          done_seen <= 1'b0;
          if (mem_fire) begin
            widx <= widx + 1'b1;
            if (widx == '0)               ctl      <= mem_rdata;
            else if (widx == IDX_W'(1))   cur_addr <= mem_rdata[AW-1:0];
            else if (widx == IDX_W'(2))   devcs    <= mem_rdata;
            else                          ndptr    <= mem_rdata[AW-1:0];
            if (widx == LAST_FETCH) state <= S_START;
          end
        end
        S_START: begin
          done_seen <= done_seen | dev_done;
          state     <= S_DECIDE;
        end
        S_DECIDE: begin
          cause <= dec_cause;
          if (dec_cause != C_NONE) begin
            ctl   <= close_ctl(ctl, dec_cause);
            devcs <= dev_status;
            state <= S_WB;
          end else begin
            state <= S_BEAT_A;
          end
        end
        S_BEAT_A, S_BEAT_B: begin
          done_seen <= done_seen | dev_done;
          if (bus_timeout) begin
            cause <= C_TERM;
            ctl   <= close_ctl(ctl, C_TERM);
            devcs <= dev_status;
            state <= S_WB;
          end else if (state == S_BEAT_A) begin
            if (fire_a) begin
              data_q <= dir_m2d ? mem_rdata : dev_rdata;
              state  <= S_BEAT_B;
            end
          end else if (fire_b) begin
            ctl[CNT_W-1:0] <= nxt_cnt;
            cur_addr       <= nxt_addr;
            state          <= S_DECIDE;
          end
        end
        S_WB: begin
          if (mem_fire) begin
            widx <= widx + 1'b1;
            if (widx == LAST_WB) begin
              widx <= '0;
              if (chain_go && (ndptr != '0)) begin
                state <= S_FETCH;
                dptr  <= ndptr;
              end else begin
                state <= S_IDLE;
              end
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // master outputs
  always_comb begin
    mem_req = 1'b0;
    mem_we  = 1'b0;
    dev_req = 1'b0;
    unique case (state)
      S_FETCH:  mem_req = 1'b1;
      S_BEAT_A: begin mem_req = dir_m2d;  dev_req = !dir_m2d; end
      S_BEAT_B: begin mem_req = !dir_m2d; mem_we = !dir_m2d; dev_req = dir_m2d; end
      S_WB:     begin mem_req = 1'b1; mem_we = 1'b1; end
      default:  ;
    endcase
  end

  always_comb begin
    if (state == S_FETCH || state == S_WB) mem_addr = dptr + (AW'(widx) << BYTE_SH);
    else                                   mem_addr = cur_addr;
    mem_wdata = data_q;
    if (state == S_WB) begin
      if (widx == '0)             mem_wdata = ctl;
      else if (widx == IDX_W'(1)) mem_wdata = WORD_W'(cur_addr);
      else                        mem_wdata = devcs;
    end
  end

  assign dev_start = (state == S_START);
  assign dev_sel   = ctl[SEL_LSB +: SEL_W];
  assign dev_cmd   = ctl[CMD_LSB +: CMD_W];
  assign dev_csin  = devcs;
  assign dev_we    = dir_m2d;
  assign dev_wdata = data_q;
  assign busy      = (state != S_IDLE);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> (!mem_req && !dev_req));
  p_fetch_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FETCH && mem_fire && widx != LAST_FETCH) |=>
      (mem_addr == $past(mem_addr) + AW'(WORD_B)));
  p_beat_shrink_r3: assert property (@(posedge clk) disable iff (!rst_n)
    beat_done |=> (ctl[CNT_W-1:0] < $past(ctl[CNT_W-1:0])));
  p_wb_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WB) |-> (cause != C_NONE));
  p_term_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_last && cause == C_TERM) |=> (state == S_IDLE));
  p_zero_link_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_last && ndptr == '0) |=> (state == S_IDLE));
endmodule

// File: tb/test_ddx_engine.sv
module test_ddx_engine;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic run_sw = 1'b0, ndptr_wr = 1'b0, stat_wr = 1'b0, bus_timeout = 1'b0;
  logic [AW-1:0] ndptr_wdata = '0;
  logic [1:0] stat_wdata = '0;
  logic mem_req, mem_we, mem_ack, dev_start, dev_req, dev_we, dev_ack, dev_done;
  logic busy, stat_d, stat_f, irq, run;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata, dev_csin, dev_wdata, dev_rdata;
  logic [31:0] dev_status = 32'h0;
  logic [2:0] dev_sel;
  logic [3:0] dev_cmd;
  logic mem_stall = 1'b0, dev_stall = 1'b0;
  int dev_cnt = 0, done_at = 0, kill_at = 0, rd_cnt = 0;
  int total = 0, bad = 0;
  logic [31:0] mem [0:1023];
  logic [2:0] st_sel;
  logic [3:0] st_cmd;
  logic [31:0] st_cs;

  typedef struct packed { logic dv; logic [31:0] addr; logic [31:0] data; } item_t;
  item_t exp_q [$];
  string tag_q [$];

  // memory and peripheral models
  assign mem_ack   = mem_req && !mem_stall;
  assign mem_rdata = mem[mem_addr[AW-1:2]];
  always @(posedge clk) if (mem_req && mem_we && mem_ack) mem[mem_addr[AW-1:2]] <= mem_wdata;
  assign dev_ack   = dev_req && !dev_stall;
  assign dev_rdata = 32'hC0DE_0000 + dev_cnt;
  assign dev_done  = dev_req && dev_ack && (done_at != 0) && (dev_cnt + 1 == done_at);
  assign run       = run_sw && !((kill_at != 0) && (dev_cnt >= kill_at));
  always @(posedge clk) if (dev_req && dev_ack) dev_cnt <= dev_cnt + 1;

  ddx_engine #(.AW(AW)) i_ddx_engine (
    .clk(clk), .rst_n(rst_n), .run(run), .ndptr_wr(ndptr_wr), .ndptr_wdata(ndptr_wdata),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .dev_start(dev_start), .dev_sel(dev_sel), .dev_cmd(dev_cmd), .dev_csin(dev_csin),
    .dev_req(dev_req), .dev_we(dev_we), .dev_wdata(dev_wdata), .dev_ack(dev_ack),
    .dev_rdata(dev_rdata), .dev_done(dev_done), .dev_status(dev_status),
    .bus_timeout(bus_timeout), .busy(busy), .stat_d(stat_d), .stat_f(stat_f), .irq(irq)
  );

  function automatic logic [31:0] mk_ctl(input logic f, d, t, iod, iof, cod, cof,
                                          input logic [3:0] cmd, input logic [2:0] sel,
                                          input logic [17:0] cnt);
    return {f, d, t, iod, iof, cod, cof, cmd, sel, cnt};
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  task automatic push(input logic dv, input logic [31:0] a, d, input string req);
    exp_q.push_back('{dv: dv, addr: a, data: d});
    tag_q.push_back(req);
  endtask

  task automatic compare(input logic dv, input logic [31:0] a, d);
    item_t it;
    string req;
    if (exp_q.size() == 0) begin
      chk(1'b0, "R3 unexpected write", d, 32'h0);
    end else begin
      it  = exp_q.pop_front();
      req = tag_q.pop_front();
      chk(it.dv == dv && (dv || it.addr == a), {req, " addr/kind"}, a, it.addr);
      chk(it.data == d, {req, " data"}, d, it.data);
    end
  endtask

  // monitor
  always @(negedge clk) if (rst_n) begin
    if (mem_req && mem_ack && !mem_we) rd_cnt <= rd_cnt + 1;
    if (dev_start) begin st_sel <= dev_sel; st_cmd <= dev_cmd; st_cs <= dev_csin; end
    if (mem_req && mem_ack && mem_we) compare(1'b0, 32'(mem_addr), mem_wdata);
    if (dev_req && dev_ack && dev_we) compare(1'b1, 32'h0, dev_wdata);
  end

  task automatic put_desc(input int p, input logic [31:0] c, a, cs, lk);
    mem[p/4] = c; mem[p/4+1] = a; mem[p/4+2] = cs; mem[p/4+3] = lk;
  endtask

  task automatic launch(input int p);
    @(negedge clk);
    ndptr_wr = 1'b1; ndptr_wdata = AW'(p); run_sw = 1'b1;
    @(negedge clk);
    ndptr_wr = 1'b0;
    while (!busy) @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic w1c(input logic [1:0] b);
    @(negedge clk); stat_wr = 1'b1; stat_wdata = b;
    @(negedge clk); stat_wr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=%h expected=%h", 32'h1, 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int rb;
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    chk(!busy && !irq && !mem_req && !dev_req, "R10 reset state",
        {28'h0, busy, irq, mem_req, dev_req}, 32'h0);
    rst_n = 1'b1;

    // A: memory to device, 10 bytes, finished, irq-on-finished, zero link stops
    put_desc(32'h100, mk_ctl(0,0,0,0,1,0,1, 4'h3, 3'd5, 18'd10), 32'h400, 32'h1234_5678, 32'h0);
    mem[32'h400/4] = 32'hA000_0000; mem[32'h404/4] = 32'hA000_0001; mem[32'h408/4] = 32'hA000_0002;
    dev_status = 32'h5A5A_0001;
    push(1, 0, 32'hA000_0000, "R3 beat0");
    push(1, 0, 32'hA000_0001, "R3 beat1");
    push(1, 0, 32'hA000_0002, "R3 partial beat");
    push(0, 32'h100, mk_ctl(1,0,0,0,1,0,1, 4'h3, 3'd5, 18'd0), "R4 finished ctl");
    push(0, 32'h104, 32'h40A, "R7 addr wb");
    push(0, 32'h108, 32'h5A5A_0001, "R7 status wb");
    rb = rd_cnt;
    launch(32'h100);
    chk(exp_q.size() == 0, "R7 all writes seen", 32'(exp_q.size()), 0);
    chk(st_sel == 3'd5 && st_cmd == 4'h3, "R2 start fields", {25'h0, st_sel, st_cmd}, {25'h0, 3'd5, 4'h3});
    chk(st_cs == 32'h1234_5678, "R2 device word", st_cs, 32'h1234_5678);
    chk(rd_cnt - rb == 7, "R9 zero link no fetch", 32'(rd_cnt - rb), 7);
    chk(stat_f && !stat_d && irq, "R8 F flag", {29'h0, stat_f, stat_d, irq}, 32'h5);

    // W1C
    w1c(2'b10);
    chk(stat_f, "R8 D clear leaves F", {31'h0, stat_f}, 1);
    w1c(2'b01);
    chk(!stat_f && !irq, "R8 F cleared", {30'h0, stat_f, irq}, 0);

    // C: chain device to memory, then zero-count with preset done bit
    put_desc(32'h200, mk_ctl(0,0,0,0,0,0,1, 4'h2, 3'd1, 18'd8), 32'h500, 32'h0, 32'h240);
    put_desc(32'h240, mk_ctl(0,1,0,0,0,0,0, 4'h1, 3'd2, 18'd0), 32'h600, 32'h7, 32'h280);
    dev_status = 32'h0000_BEEF;
    push(0, 32'h500, 32'hC0DE_0000 + dev_cnt, "R3 dev-to-mem beat0");
    push(0, 32'h504, 32'hC0DE_0001 + dev_cnt, "R3 dev-to-mem beat1");
    push(0, 32'h200, mk_ctl(1,0,0,0,0,0,1, 4'h2, 3'd1, 18'd0), "R4 first ctl");
    push(0, 32'h204, 32'h508, "R3 first addr");
    push(0, 32'h208, 32'h0000_BEEF, "R7 first status");
    push(0, 32'h240, mk_ctl(1,1,0,0,0,0,0, 4'h1, 3'd2, 18'd0), "R7 sticky done + R4 zero count");
    push(0, 32'h244, 32'h600, "R4 zero count addr");
    push(0, 32'h248, 32'h0000_BEEF, "R7 second status");
    rb = rd_cnt;
    launch(32'h200);
    chk(exp_q.size() == 0, "R9 chained writes seen", 32'(exp_q.size()), 0);
    chk(rd_cnt - rb == 8, "R9 chain once then halt", 32'(rd_cnt - rb), 8);
    chk(!stat_f && !stat_d, "R8 no irq enable no flag", {30'h0, stat_f, stat_d}, 0);

    // D: device done after two beats, done irq, no chain-on-done
    put_desc(32'h300, mk_ctl(0,0,0,1,0,0,1, 4'h1, 3'd3, 18'd40), 32'h700, 32'h0, 32'h340);
    mem[32'h700/4] = 32'hB000_0000; mem[32'h704/4] = 32'hB000_0001;
    dev_status = 32'h0000_0D0E;
    done_at = dev_cnt + 2;
    push(1, 0, 32'hB000_0000, "R5 beat0");
    push(1, 0, 32'hB000_0001, "R5 beat1");
    push(0, 32'h300, mk_ctl(0,1,0,1,0,0,1, 4'h1, 3'd3, 18'd32), "R5 done ctl");
    push(0, 32'h304, 32'h708, "R5 done addr");
    push(0, 32'h308, 32'h0000_0D0E, "R5 done status");
    rb = rd_cnt;
    launch(32'h300);
    done_at = 0;
    chk(rd_cnt - rb == 6, "R9 done without chain bit halts", 32'(rd_cnt - rb), 6);
    chk(stat_d && !stat_f && irq, "R8 D flag", {29'h0, stat_d, stat_f, irq}, 32'h5);
    w1c(2'b10);
    chk(!stat_d && !irq, "R8 D cleared", {30'h0, stat_d, irq}, 0);

    // E: run dropped after one beat
    put_desc(32'h380, mk_ctl(0,0,0,1,1,1,1, 4'h1, 3'd4, 18'd20), 32'h780, 32'h0, 32'h100);
    mem[32'h780/4] = 32'hE000_0000;
    dev_status = 32'h0000_7E57;
    kill_at = dev_cnt + 1;
    push(1, 0, 32'hE000_0000, "R6 beat before abort");
    push(0, 32'h380, mk_ctl(0,0,1,1,1,1,1, 4'h1, 3'd4, 18'd16), "R6 terminated ctl");
    push(0, 32'h384, 32'h784, "R6 terminated addr");
    push(0, 32'h388, 32'h0000_7E57, "R6 terminated status");
    rb = rd_cnt;
    launch(32'h380);
    chk(rd_cnt - rb == 5, "R6 terminated never chains", 32'(rd_cnt - rb), 5);
    chk(!stat_d && !stat_f, "R6 no flags on abort", {30'h0, stat_d, stat_f}, 0);
    kill_at = 0;

    // F: bus timeout on a stalled beat, preset finished bit stays
    put_desc(32'h3C0, mk_ctl(1,0,0,0,0,0,1, 4'h1, 3'd6, 18'd12), 32'h7C0, 32'h0, 32'h100);
    dev_status = 32'h0000_0BAD;
    dev_stall = 1'b1;
    push(0, 32'h3C0, mk_ctl(1,0,1,0,0,0,1, 4'h1, 3'd6, 18'd12), "R6 timeout ctl + R7 sticky");
    push(0, 32'h3C4, 32'h7C0, "R6 timeout addr");
    push(0, 32'h3C8, 32'h0000_0BAD, "R6 timeout status");
    rb = rd_cnt;
    @(negedge clk);
    ndptr_wr = 1'b1; ndptr_wdata = AW'(32'h3C0); run_sw = 1'b1;
    @(negedge clk);
    ndptr_wr = 1'b0;
    while (!dev_req) @(negedge clk);
    bus_timeout = 1'b1;
    @(negedge clk);
    bus_timeout = 1'b0;
    dev_stall = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, "R6 timeout writes seen", 32'(exp_q.size()), 0);
    chk(rd_cnt - rb == 5, "R6 timeout no chain", 32'(rd_cnt - rb), 5);
    chk(!busy && !mem_req, "R10 idle after list", {30'h0, busy, mem_req}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule